// File: doc/BRIEF.md
# Three-Register Stack Processor Core

This block is a small synchronous processor for hard-real-time control. It reads 16-bit instructions from an external read-only program store. It executes them on a stack of three data registers (A on top, then B, then C) with a program pointer P. There are three instructions: push a constant, relative jump and add. Each one costs a fixed number of clock cycles, so the running time of a program can be worked out in advance. A counter adds up the cost of every instruction that completes.

A host sets a code window with a lower bound (inclusive) and an upper bound (exclusive), then pulses start. The core begins at the lower bound and runs while P stays inside the window. It stops with a halted flag when P leaves the window. It also stops, and raises an error flag, when it meets an opcode it does not know. The program store is only ever read. All register state can be seen on dedicated output ports.

Top module: `stack3_core`

## Requirements
- R1: While reset is high, and on the first cycle after it, A, B, C, P, the cycle count, halted and the error flag all read zero.
- R2: A start pulse accepted while idle or halted clears A, B, C and the cycle count, and sets P to the lower bound of the window.
- R3: The instruction word puts the opcode in bits 15:12 and a signed 12-bit operand in bits 11:0. Opcode 0 pushes the operand, sign-extended to 16 bits: A gets the operand, B gets the old A, C gets the old B, and P advances by one.
- R4: Opcode 1 sets P to P + operand + 1, modulo the pointer width, and leaves A, B and C unchanged.
- R5: Opcode 2 sets A to A + B modulo 2^16 and B to the old C, leaves C unchanged, and advances P by one.
- R6: The cycle count grows by 1 for opcode 0, 2 for opcode 1 and 1 for opcode 2 when each instruction completes. An instruction occupies one fetch cycle plus its cost.
- R7: Execution continues only while lower <= P < upper. The cycle in which P leaves the window sets halted, with the error flag low. After that A, B, C, P and the count hold until the next start.
- R8: Opcodes 3 to 15 halt the core with the error flag set. A, B, C, P and the count are left unchanged.
- R9: A start with lower >= upper halts at once without executing anything. P equals the lower bound and the count stays at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin execution from the window's lower bound |
| win_lo | input | AW | Lower window bound, inclusive |
| win_hi | input | AW | Upper window bound, exclusive |
| rom_addr | output | AW | Program store read address (equals P) |
| rom_data | input | IW | Program store data, one cycle after the address |
| obs_a | output | DW | Stack top A |
| obs_b | output | DW | Stack register B |
| obs_c | output | DW | Stack register C |
| obs_p | output | AW | Program pointer |
| cyc_cnt | output | CW | Accumulated instruction cycle cost |
| halted | output | 1 | Core has stopped |
| bad_op | output | 1 | Stop was caused by an unknown opcode |

## Verification
The assertions check on every cycle that P lies inside the window while the core runs and outside it after a normal halt. They also check that the halted state freezes all visible registers, that the error flag never appears without halted, that the count only ever steps by 1 or 2, and that A changes only in a cycle where the count changes. Only the bench's scenarios can show that each opcode produces the exact stack values, pointer target and completion cycle. These scenarios include a backward jump, 16-bit wraparound, an exit below the lower bound, a sweep of all sixteen opcodes and empty windows. The bench checks each result against its own model at the cycle where the instruction should complete.

// File: rtl/stk_pkg.sv
package stk_pkg;
  localparam int OPC_W  = 4;
  localparam int COST_W = 2;

  localparam logic [OPC_W-1:0] OPC_PUSH = 4'd0;
  localparam logic [OPC_W-1:0] OPC_JUMP = 4'd1;
  localparam logic [OPC_W-1:0] OPC_SUM  = 4'd2;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_EXEC, ST_HALT} core_st_e;

  function automatic logic op_known(input logic [OPC_W-1:0] opc);
    return (opc == OPC_PUSH) || (opc == OPC_JUMP) || (opc == OPC_SUM);
  endfunction

  function automatic logic [COST_W-1:0] op_cost(input logic [OPC_W-1:0] opc);
    case (opc)
      OPC_JUMP: return 2'd2;
      default:  return 2'd1;
    endcase
  endfunction
endpackage

// File: rtl/stk_ctrl.sv
module stk_ctrl
  import stk_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [AW-1:0]       win_lo,
  input  logic [AW-1:0]       win_hi,
  input  logic [OPC_W-1:0]    opc,
  input  logic [AW-1:0]       nxt_p,
  output logic                load,
  output logic                retire,
  output logic [COST_W-1:0]   cost,
  output logic                halted,
  output logic                bad_op,
  output logic                running,
  output logic [AW-1:0]       lo_q,
  output logic [AW-1:0]       hi_q
);
  core_st_e          st_q;
  logic [COST_W-1:0] wait_q;
  logic              known;
  logic              in_win;

  assign known   = op_known(opc);
  assign cost    = op_cost(opc);
  assign load    = start && (st_q == ST_IDLE || st_q == ST_HALT);
  assign retire  = (st_q == ST_EXEC) && known && (wait_q == cost - 2'd1);
  assign in_win  = (nxt_p >= lo_q) && (nxt_p < hi_q);
  assign running = (st_q == ST_FETCH) || (st_q == ST_EXEC);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      wait_q <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      halted <= 1'b0;
      bad_op <= 1'b0;
    end else if (load) begin
      lo_q   <= win_lo;
      hi_q   <= win_hi;
      bad_op <= 1'b0;
      wait_q <= '0;
      if (win_lo < win_hi) begin
        st_q   <= ST_FETCH;
        halted <= 1'b0;
      end else begin
        st_q   <= ST_HALT;
        halted <= 1'b1;
      end
    end else begin
      case (st_q)
        ST_FETCH: begin
          st_q   <= ST_EXEC;
          wait_q <= '0;
        end
        ST_EXEC: begin
          if (!known) begin
            st_q   <= ST_HALT;
            halted <= 1'b1;
            bad_op <= 1'b1;
          end else if (retire) begin
            wait_q <= '0;
            if (in_win) begin
              st_q <= ST_FETCH;
            end else begin
              st_q   <= ST_HALT;
              halted <= 1'b1;
            end
          end else begin
            wait_q <= wait_q + 2'd1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/stk_regs.sv
module stk_regs
  import stk_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 8,
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          retire,
  input  logic [AW-1:0] start_p,
  input  logic [IW-1:0] instr,
  output logic [DW-1:0] a_q,
  output logic [DW-1:0] b_q,
  output logic [DW-1:0] c_q,
  output logic [AW-1:0] p_q,
  output logic [AW-1:0] nxt_p
);
  localparam int OPND_W = IW - OPC_W;

  logic [OPC_W-1:0]  opc;
  logic [OPND_W-1:0] opnd;
  logic [DW-1:0]     opnd_x;
  logic [AW-1:0]     off_p;

  assign opc    = instr[IW-1:OPND_W];
  assign opnd   = instr[OPND_W-1:0];
  assign opnd_x = {{(DW-OPND_W){opnd[OPND_W-1]}}, opnd};

  generate
    if (AW <= OPND_W) begin : g_off_trunc
      assign off_p = opnd[AW-1:0];
    end else begin : g_off_ext
      assign off_p = {{(AW-OPND_W){opnd[OPND_W-1]}}, opnd};
    end
  endgenerate

  assign nxt_p = (opc == OPC_JUMP) ? (p_q + off_p + {{(AW-1){1'b0}}, 1'b1})
                                   : (p_q + {{(AW-1){1'b0}}, 1'b1});

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= '0;
      b_q <= '0;
      c_q <= '0;
      p_q <= '0;
    end else if (load) begin
      a_q <= '0;
      b_q <= '0;
      c_q <= '0;
      p_q <= start_p;
    end else if (retire) begin
      p_q <= nxt_p;
      case (opc)
        OPC_PUSH: begin
          a_q <= opnd_x;
          b_q <= a_q;
          c_q <= b_q;
        end
        OPC_SUM: begin
          a_q <= a_q + b_q;
          b_q <= c_q;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/stk_cyc.sv
module stk_cyc
  import stk_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              retire,
  input  logic [COST_W-1:0] cost,
  output logic [CW-1:0]     cnt
);
  always_ff @(posedge clk) begin
    if (rst || load) cnt <= '0;
    else if (retire) cnt <= cnt + {{(CW-COST_W){1'b0}}, cost};
  end
endmodule

// File: rtl/stack3_core.sv
module stack3_core
  import stk_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 8,
  parameter int IW = 16,
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] win_lo,
  input  logic [AW-1:0] win_hi,
  output logic [AW-1:0] rom_addr,
  input  logic [IW-1:0] rom_data,
  output logic [DW-1:0] obs_a,
  output logic [DW-1:0] obs_b,
  output logic [DW-1:0] obs_c,
  output logic [AW-1:0] obs_p,
  output logic [CW-1:0] cyc_cnt,
  output logic          halted,
  output logic          bad_op
);
  logic              load, retire, running;
  logic [COST_W-1:0] cost;
  logic [AW-1:0]     nxt_p, win_lo_q, win_hi_q;

  stk_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .win_lo(win_lo), .win_hi(win_hi),
    .opc(rom_data[IW-1:IW-OPC_W]), .nxt_p(nxt_p), .load(load), .retire(retire),
    .cost(cost), .halted(halted), .bad_op(bad_op), .running(running),
    .lo_q(win_lo_q), .hi_q(win_hi_q)
  );

  stk_regs #(.DW(DW), .AW(AW), .IW(IW)) u_regs (
    .clk(clk), .rst(rst), .load(load), .retire(retire), .start_p(win_lo),
    .instr(rom_data), .a_q(obs_a), .b_q(obs_b), .c_q(obs_c), .p_q(obs_p),
    .nxt_p(nxt_p)
  );

  stk_cyc #(.CW(CW)) u_cyc (
    .clk(clk), .rst(rst), .load(load), .retire(retire), .cost(cost),
    .cnt(cyc_cnt)
  );

  assign rom_addr = obs_p;
endmodule

// File: rtl/stk_chk.sv
module stk_chk #(
  parameter int DW = 16,
  parameter int AW = 8,
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic [DW-1:0] a,
  input logic [DW-1:0] b,
  input logic [DW-1:0] c,
  input logic [AW-1:0] p,
  input logic [CW-1:0] cyc,
  input logic          halted,
  input logic          bad_op,
  input logic          running,
  input logic [AW-1:0] lo,
  input logic [AW-1:0] hi
);
  // R7
  halt_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (halted && !start) |=> ($stable(a) && $stable(b) && $stable(c) && $stable(p) && $stable(cyc)));

  // R7
  run_window_chk: assert property (@(posedge clk) disable iff (rst)
    running |-> (p >= lo && p < hi));

  // R7
  halt_outside_chk: assert property (@(posedge clk) disable iff (rst)
    (halted && !bad_op) |-> (p < lo || p >= hi));

  // R8
  bad_halts_chk: assert property (@(posedge clk) disable iff (rst)
    bad_op |-> halted);

  // R6
  cyc_step_chk: assert property (@(posedge clk) disable iff (rst)
    ((cyc != $past(cyc)) && !$past(start)) |->
      ((cyc - $past(cyc)) == CW'(1) || (cyc - $past(cyc)) == CW'(2)));

  // R6
  a_with_cost_chk: assert property (@(posedge clk) disable iff (rst)
    ((a != $past(a)) && !$past(start)) |-> (cyc != $past(cyc)));
endmodule

bind stack3_core stk_chk #(.DW(DW), .AW(AW), .CW(CW)) chk_i (
  .clk(clk), .rst(rst), .start(start), .a(obs_a), .b(obs_b), .c(obs_c),
  .p(obs_p), .cyc(cyc_cnt), .halted(halted), .bad_op(bad_op),
  .running(running), .lo(win_lo_q), .hi(win_hi_q)
);

// File: tb/stack3_core_tb_top.sv
`timescale 1ns/1ps
module stack3_core_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  lo = '0, hi = '0;
  logic [7:0]  rom_addr;
  logic [15:0] rom_q;
  logic [15:0] a, b, c;
  logic [7:0]  p;
  logic [31:0] cyc;
  logic        halted, bad;
  logic [15:0] rom_m [0:255];
  int n_chk = 0, n_err = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  always_ff @(posedge clk) rom_q <= rom_m[rom_addr];

  stack3_core dut_i (
    .clk(clk), .rst(rst), .start(start), .win_lo(lo), .win_hi(hi),
    .rom_addr(rom_addr), .rom_data(rom_q), .obs_a(a), .obs_b(b), .obs_c(c),
    .obs_p(p), .cyc_cnt(cyc), .halted(halted), .bad_op(bad)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_prog(input logic [7:0] l, input logic [7:0] h);
    logic [15:0] ma, mb, mc, ins;
    logic [7:0]  mp;
    logic [3:0]  op;
    int          mcyc, off, steps;
    bit          done;
    string       tg;
    lo = l; hi = h;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    ma = '0; mb = '0; mc = '0; mp = l; mcyc = 0;
    chk("R2", "start P", {24'd0, p}, {24'd0, l});
    chk("R2", "start A", {16'd0, a}, 32'd0);
    chk("R2", "start cyc", cyc, 32'd0);
    if (!(l < h)) begin
      chk("R9", "empty halted", {31'd0, halted}, 32'd1);
      chk("R9", "empty err", {31'd0, bad}, 32'd0);
      repeat (3) @(negedge clk);
      chk("R9", "empty P", {24'd0, p}, {24'd0, l});
      chk("R9", "empty cyc", cyc, 32'd0);
      return;
    end
    chk("R2", "running", {31'd0, halted}, 32'd0);
    done = 0; steps = 0;
    while (!done && steps < 64) begin
      steps++;
      ins = rom_m[mp];
      op  = ins[15:12];
      off = int'($signed(ins[11:0]));
      if (op > 4'd2) begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R8", "bad halted", {31'd0, halted}, 32'd1);
        chk("R8", "bad flag", {31'd0, bad}, 32'd1);
        chk("R8", "bad A", {16'd0, a}, {16'd0, ma});
        chk("R8", "bad P", {24'd0, p}, {24'd0, mp});
        chk("R8", "bad cyc", cyc, mcyc);
        return;
      end
      case (op)
        4'd0: begin
          mc = mb; mb = ma; ma = 16'(off); mp = mp + 8'd1; mcyc += 1; tg = "R3";
        end
        4'd1: begin
          mp = 8'(int'(mp) + off + 1); mcyc += 2; tg = "R4";
        end
        default: begin
          ma = ma + mb; mb = mc; mp = mp + 8'd1; mcyc += 1; tg = "R5";
        end
      endcase
      repeat ((op == 4'd1) ? 3 : 2) @(posedge clk);
      @(negedge clk);
      chk(tg, "A", {16'd0, a}, {16'd0, ma});
      chk(tg, "B", {16'd0, b}, {16'd0, mb});
      chk(tg, "C", {16'd0, c}, {16'd0, mc});
      chk(tg, "P", {24'd0, p}, {24'd0, mp});
      chk("R6", "cycle count", cyc, mcyc);
      if (mp < l || mp >= h) begin
        chk("R7", "exit halted", {31'd0, halted}, 32'd1);
        chk("R7", "exit err", {31'd0, bad}, 32'd0);
        done = 1;
      end else begin
        chk("R7", "in window", {31'd0, halted}, 32'd0);
      end
    end
    repeat (5) @(negedge clk);
    chk("R7", "frozen A", {16'd0, a}, {16'd0, ma});
    chk("R7", "frozen B", {16'd0, b}, {16'd0, mb});
    chk("R7", "frozen P", {24'd0, p}, {24'd0, mp});
    chk("R7", "frozen cyc", cyc, mcyc);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) rom_m[i] = 16'h0000;
    rom_m[4]  = 16'h0005; rom_m[5]  = 16'h0FFD; rom_m[6]  = 16'h2000;
    rom_m[7]  = 16'h0FFF; rom_m[8]  = 16'h0001; rom_m[9]  = 16'h2000;
    rom_m[10] = 16'h1001; rom_m[11] = 16'h1003; rom_m[12] = 16'h1FFE;
    rom_m[40] = 16'h07FF; rom_m[41] = 16'h0800; rom_m[42] = 16'h2000;
    rom_m[43] = 16'h3000;
    rom_m[200] = 16'h1FFA;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "reset A", {16'd0, a}, 32'd0);
    chk("R1", "reset P", {24'd0, p}, 32'd0);
    chk("R1", "reset cyc", cyc, 32'd0);
    chk("R1", "reset halted", {31'd0, halted}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "post reset B", {16'd0, b}, 32'd0);
    chk("R1", "post reset C", {16'd0, c}, 32'd0);
    chk("R1", "post reset err", {31'd0, bad}, 32'd0);
    run_prog(8'd4, 8'd14);    // R4 backward jump, R5 wrap
    run_prog(8'd40, 8'd50);   // R8 unknown opcode after pushes
    run_prog(8'd200, 8'd210); // R7 exit below lower bound
    run_prog(8'd60, 8'd60);   // R9 empty window
    run_prog(8'd70, 8'd65);   // R9 inverted window
    for (int o = 0; o < 16; o++) begin
      rom_m[100] = {4'(o), 12'h123};
      run_prog(8'd100, 8'd101);
    end
    for (int k = 0; k < 8; k++) begin
      rom_m[120] = {4'd1, 12'(k * 37 - 140)};
      run_prog(8'd120, 8'd121);
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule